// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the iterative multiply and divide engine of a 32-bit integer core. It owns two result registers, HI and LO. A one-cycle start pulse with an operation code and two source operands launches a signed or unsigned multiply, or a signed or unsigned divide. The unit iterates one bit per cycle, then spends one extra cycle correcting signs before it writes HI and LO together.

A multiply leaves the upper half of the 64-bit product in HI and the lower half in LO. A divide computes the first source divided by the second source. The quotient goes to LO and the remainder to HI. Both registers are visible at all times on two read ports, which serve as the move-from-HI and move-from-LO paths.

A busy flag covers the whole operation and a one-cycle done pulse marks completion. A start that arrives while the unit is busy is dropped. A divide by zero runs its full length but leaves HI and LO untouched.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, hi_o and lo_o read 0, and busy_o and done_o are low.
- R2: Operation code 2'b01 (unsigned multiply) sets hi_o to the upper 32 bits and lo_o to the lower 32 bits of the unsigned 64-bit product src_a_i * src_b_i.
- R3: Operation code 2'b00 (signed multiply) sets {hi_o, lo_o} to the two's complement 64-bit product of src_a_i and src_b_i.
- R4: Operation code 2'b11 (unsigned divide) sets lo_o to the quotient src_a_i / src_b_i and hi_o to the remainder.
- R5: Operation code 2'b10 (signed divide) rounds the quotient toward zero and gives the remainder the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF yields quotient 0x80000000 and remainder 0.
- R6: An accepted start makes busy_o high for exactly 33 cycles. In the following cycle, done_o is high for one cycle with busy_o low, and the new results are already visible on hi_o and lo_o.
- R7: A start_i pulse while busy_o is high is ignored. The running operation finishes with its own result, and no further operation follows.
- R8: A divide (signed or unsigned) with src_b_i equal to 0 leaves hi_o and lo_o unchanged and still raises done_o after the usual 33 busy cycles.
- R9: hi_o and lo_o keep their previous values for as long as busy_o is high. They change only at the edge that raises done_o.
- R10: A start_i presented in the cycle where done_o is high is accepted, and busy_o is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch request, sampled when not busy |
| op_i | input | 2 | Operation: bit 1 selects divide, bit 0 selects unsigned |
| src_a_i | input | 32 | First source: multiplicand or dividend |
| src_b_i | input | 32 | Second source: multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | HI register read port |
| lo_o | output | 32 | LO register read port |

## Verification
Two functions can meet in the same cycle: the completion of one operation and the arrival of a new start.

The bench provokes this in two ways. First, it asserts start_i in the last busy cycle, where the request must be dropped. Second, it asserts start_i in the done cycle itself, where the request must be taken.

It judges the outcome by the final HI/LO values, by the busy cycle count, and by busy_o in the cycle after the request. A second overlap concerns the register ports: a new launch coincides with the results of the previous operation being read, and the bench checks that those results survive untouched through the busy period.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    // bit 1: divide, bit 0: unsigned
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } hilo_op_e;

    localparam int unsigned FIX_CYCLES = 1;

endpackage

// File: rtl/hilo_sign_prep.sv
module hilo_sign_prep #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] mag_a_o,
    output logic [WIDTH-1:0] mag_b_o,
    output logic             neg_lo_o,
    output logic             neg_hi_o,
    output logic             div_zero_o
);
    logic is_signed;
    logic is_div;
    logic a_neg;
    logic b_neg;

    always_comb begin
        is_signed  = ~op_i[0];
        is_div     = op_i[1];
        a_neg      = is_signed & a_i[WIDTH-1];
        b_neg      = is_signed & b_i[WIDTH-1];
        mag_a_o    = a_neg ? (~a_i + 1'b1) : a_i;
        mag_b_o    = b_neg ? (~b_i + 1'b1) : b_i;
        // product or quotient sign
        neg_lo_o   = a_neg ^ b_neg;
        // remainder follows the dividend; for a product the whole value flips
        neg_hi_o   = is_div ? a_neg : (a_neg ^ b_neg);
        div_zero_o = is_div & (b_i == '0);
    end
endmodule

// File: rtl/hilo_iter_step.sv
module hilo_iter_step #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             is_div_i,
    input  logic [WIDTH-1:0] w_hi_i,
    input  logic [WIDTH-1:0] w_lo_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] w_hi_o,
    output logic [WIDTH-1:0] w_lo_o
);
    logic [WIDTH:0]   sum;
    logic [WIDTH:0]   shl;
    logic [WIDTH-1:0] trial;
    logic             fits;

    always_comb begin
        // shift-and-add: add the multiplicand into the upper half, then shift right
        sum   = {1'b0, w_hi_i} + (w_lo_i[0] ? {1'b0, b_i} : '0);
        // restoring division: shift the partial remainder left by one dividend bit
        shl   = {w_hi_i, w_lo_i[WIDTH-1]};
        fits  = (shl >= {1'b0, b_i});
        trial = shl[WIDTH-1:0] - b_i;
        if (is_div_i) begin
            w_hi_o = fits ? trial : shl[WIDTH-1:0];
            w_lo_o = {w_lo_i[WIDTH-2:0], fits};
        end else begin
            w_hi_o = sum[WIDTH:1];
            w_lo_o = {sum[0], w_lo_i[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/hilo_sign_fix.sv
module hilo_sign_fix #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             is_div_i,
    input  logic             neg_lo_i,
    input  logic             neg_hi_i,
    input  logic [WIDTH-1:0] w_hi_i,
    input  logic [WIDTH-1:0] w_lo_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int unsigned PW = 2 * WIDTH;

    logic [PW-1:0] prod;

    always_comb begin
        prod = {w_hi_i, w_lo_i};
        if (neg_lo_i) begin
            prod = ~prod + 1'b1;
        end
        if (is_div_i) begin
            lo_o = neg_lo_i ? (~w_lo_i + 1'b1) : w_lo_i;
            hi_o = neg_hi_i ? (~w_hi_i + 1'b1) : w_hi_i;
        end else begin
            hi_o = prod[PW-1:WIDTH];
            lo_o = prod[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] src_a_i,
    input  logic [WIDTH-1:0] src_b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int unsigned CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CW-1:0]    cnt;
        logic             is_div;
        logic             neg_lo;
        logic             neg_hi;
        logic             dz;
        logic [WIDTH-1:0] w_hi;
        logic [WIDTH-1:0] w_lo;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [WIDTH-1:0] mag_a, mag_b;
    logic             p_neg_lo, p_neg_hi, p_dz;
    logic [WIDTH-1:0] step_hi, step_lo;
    logic [WIDTH-1:0] fix_hi, fix_lo;

    hilo_sign_prep #(.WIDTH(WIDTH)) prep_i (
        .op_i      (op_i),
        .a_i       (src_a_i),
        .b_i       (src_b_i),
        .mag_a_o   (mag_a),
        .mag_b_o   (mag_b),
        .neg_lo_o  (p_neg_lo),
        .neg_hi_o  (p_neg_hi),
        .div_zero_o(p_dz)
    );

    hilo_iter_step #(.WIDTH(WIDTH)) step_i (
        .is_div_i(st_q.is_div),
        .w_hi_i  (st_q.w_hi),
        .w_lo_i  (st_q.w_lo),
        .b_i     (st_q.b),
        .w_hi_o  (step_hi),
        .w_lo_o  (step_lo)
    );

    hilo_sign_fix #(.WIDTH(WIDTH)) fix_i (
        .is_div_i(st_q.is_div),
        .neg_lo_i(st_q.neg_lo),
        .neg_hi_i(st_q.neg_hi),
        .w_hi_i  (st_q.w_hi),
        .w_lo_i  (st_q.w_lo),
        .hi_o    (fix_hi),
        .lo_o    (fix_lo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
                st_d.is_div = op_i[1];
                st_d.neg_lo = p_neg_lo;
                st_d.neg_hi = p_neg_hi;
                st_d.dz     = p_dz;
                st_d.w_hi   = '0;
                st_d.w_lo   = mag_a;
                st_d.b      = mag_b;
            end
        end else if (st_q.cnt == LAST_STEP) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            if (!st_q.dz) begin
                st_d.hi = fix_hi;
                st_d.lo = fix_lo;
            end
        end else begin
            st_d.w_hi = step_hi;
            st_d.w_lo = step_lo;
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign hi_o   = st_q.hi;
    assign lo_o   = st_q.lo;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [1:0]       op_i,
    input logic [WIDTH-1:0] src_a_i,
    input logic [WIDTH-1:0] src_b_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);
    localparam int unsigned BW = $clog2(WIDTH + 2) + 1;
    localparam logic [BW-1:0] BUSY_LEN = BW'(WIDTH + hilo_pkg::FIX_CYCLES);

    logic [BW-1:0]      busy_cnt;
    logic [1:0]         cap_op;
    logic [WIDTH-1:0]   cap_a, cap_b;
    logic [WIDTH-1:0]   cap_hi, cap_lo;
    logic [2*WIDTH-1:0] uprod, sprod;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            cap_op   <= '0;
            cap_a    <= '0;
            cap_b    <= '0;
            cap_hi   <= '0;
            cap_lo   <= '0;
        end else begin
            busy_cnt <= busy_o ? busy_cnt + 1'b1 : '0;
            if (start_i && !busy_o) begin
                cap_op <= op_i;
                cap_a  <= src_a_i;
                cap_b  <= src_b_i;
                cap_hi <= hi_o;
                cap_lo <= lo_o;
            end
        end
    end

    always_comb begin
        uprod = {{WIDTH{1'b0}}, cap_a} * {{WIDTH{1'b0}}, cap_b};
        sprod = {{WIDTH{cap_a[WIDTH-1]}}, cap_a} * {{WIDTH{cap_b[WIDTH-1]}}, cap_b};
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == BUSY_LEN) && !busy_o);
    // R7
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> busy_cnt < BUSY_LEN);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R9
    hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $stable(hi_o) && $stable(lo_o));
    // R8
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_op[1] && cap_b == '0) |-> (hi_o == cap_hi) && (lo_o == cap_lo));
    // R2
    mulu_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_op == hilo_pkg::OP_MUL_U) |-> {hi_o, lo_o} == uprod);
    // R3
    muls_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_op == hilo_pkg::OP_MUL_S) |-> {hi_o, lo_o} == sprod);
endmodule

bind hilo_muldiv_unit hilo_muldiv_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/hilo_muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module hilo_muldiv_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic        busy_o, done_o;
    logic [31:0] hi_o, lo_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hilo_muldiv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .busy_o(busy_o),
        .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    // op, a, b, expected hi, expected lo
    localparam logic [129:0] VEC [0:13] = '{
        {2'b01, 32'h00000003, 32'h00000005, 32'h00000000, 32'h0000000F}, // R2
        {2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001}, // R2
        {2'b01, 32'h80000000, 32'h00000002, 32'h00000001, 32'h00000000}, // R2
        {2'b00, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R3
        {2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000001}, // R3
        {2'b00, 32'h80000000, 32'h00000002, 32'hFFFFFFFF, 32'h00000000}, // R3
        {2'b11, 32'd100,      32'd7,        32'd2,        32'd14},       // R4
        {2'b11, 32'hFFFFFFFF, 32'h00000010, 32'h0000000F, 32'h0FFFFFFF}, // R4
        {2'b11, 32'hFFFFFFF9, 32'h00000002, 32'h00000001, 32'h7FFFFFFC}, // R4
        {2'b11, 32'd5,        32'd9,        32'd5,        32'd0},        // R4
        {2'b10, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD}, // R5
        {2'b10, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD}, // R5
        {2'b10, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000003}, // R5
        {2'b10, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000}  // R5
    };

    function automatic string req_of(input logic [1:0] op);
        case (op)
            2'b01:   return "R2";
            2'b00:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done_o && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] b, output int cyc);
        launch(op, a, b);
        wait_done(cyc);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {hi_o, lo_o}, 64'h0);
        check("R1", {62'h0, busy_o, done_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {hi_o, lo_o}, 64'h0);

        // table walk, R2..R5 with R6 cycle count
        for (int i = 0; i < 14; i++) begin
            run_op(VEC[i][129:128], VEC[i][127:96], VEC[i][95:64], cyc);
            check(req_of(VEC[i][129:128]), {hi_o, lo_o}, VEC[i][63:0]);
            check("R6", 64'(cyc), 64'd33);
        end
        check("R6", {62'h0, busy_o, done_o}, 64'h1);
        @(negedge clk);
        check("R6", {62'h0, busy_o, done_o}, 64'h0);

        // R9: previous results hold through a busy period
        run_op(2'b01, 32'd3, 32'd5, cyc);
        launch(2'b11, 32'd100, 32'd7);
        repeat (10) @(negedge clk);
        check("R9", {63'h0, busy_o}, 64'h1);
        check("R9", {hi_o, lo_o}, 64'h0000_0000_0000_000F);
        wait_done(cyc);
        check("R9", {hi_o, lo_o}, {32'd2, 32'd14});

        // R7: starts during busy (middle and last busy cycle) are dropped
        launch(2'b01, 32'd6, 32'd7);
        cyc = 0;
        while (!done_o && cyc < 100) begin
            cyc++;
            if (cyc == 5 || cyc == 33) begin
                start_i = 1'b1; op_i = 2'b11; src_a_i = 32'd9; src_b_i = 32'd3;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R7", {hi_o, lo_o}, 64'd42);
        check("R7", 64'(cyc), 64'd33);
        @(negedge clk);
        check("R7", {63'h0, busy_o}, 64'h0);
        check("R7", {hi_o, lo_o}, 64'd42);

        // R8: division by zero keeps HI/LO and completes
        run_op(2'b00, 32'hFFFFFFFF, 32'h1, cyc);
        run_op(2'b11, 32'd123, 32'd0, cyc);
        check("R8", {hi_o, lo_o}, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8", 64'(cyc), 64'd33);
        run_op(2'b10, 32'hFFFFFFFB, 32'd0, cyc);
        check("R8", {hi_o, lo_o}, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8", 64'(cyc), 64'd33);

        // R10: start in the done cycle is taken
        run_op(2'b01, 32'd4, 32'd4, cyc);
        check("R10", {63'h0, done_o}, 64'h1);
        start_i = 1'b1; op_i = 2'b01; src_a_i = 32'd2; src_b_i = 32'd3;
        @(negedge clk);
        start_i = 1'b0;
        check("R10", {63'h0, busy_o}, 64'h1);
        check("R10", {hi_o, lo_o}, 64'd16);
        wait_done(cyc);
        check("R10", {hi_o, lo_o}, 64'd6);
        check("R10", 64'(cyc), 64'd33);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule